// File: doc/BRIEF.md
# Regulator Control Register Slave (two-wire serial)

This block lets a host on a two-wire I2C-compatible bus read and write a small bank of 8-bit control registers that steer a voltage regulator controller. Both bus lines are brought into the system clock domain through synchronizers. The block then finds START, REPEATED START and STOP conditions, compares the 7-bit device address, and handles single or sequential transfers in both directions with a register pointer that advances by itself.

The register contents leave the block as one flat vector. Downstream logic reacts to a one-cycle write strobe that is raised on the same clock edge on which the slave begins pulling SDA low to acknowledge the data byte, so a new setting takes effect at the acknowledge. The bank returns to its default values whenever either of two supply-undervoltage flags is high. The pad driver is outside the block: the slave only reports when SDA must be pulled low.

Top module: `regctl_i2c_slave`

## Requirements
- R1: An address byte whose upper seven bits equal 1100000 is acknowledged, with bit 0 giving the direction (0 = write, 1 = read). Any other address is not acknowledged.
- R2: For every byte the slave receives and accepts, it pulls SDA low during the ninth SCL clock. It changes its SDA drive only while SCL is low.
- R3: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A REPEATED START restarts the address phase in the same way as a START.
- R4: Every 8-bit pointer value is acknowledged. Pointers at or above the register count (8) read back as 0x00 and silently drop writes.
- R5: In a write, the first byte after the address is the pointer. Each following data byte goes to the pointer and then advances it by one.
- R6: Read data is sent MSB first starting at the current pointer, which advances after each byte. The slave keeps sending while the master acknowledges, and after a master NACK it leaves SDA released.
- R7: After a STOP, or after an address that does not match, the slave acknowledges nothing and writes nothing until the next START.
- R8: While either undervoltage flag is high, all registers return to their defaults (register i defaults to 0x10 + i).
- R9: A write to an implemented register updates the register, pulses wr_stb_o for one cycle and raises sda_pull_o, all on the same clock edge.
- R10: A synchronous reset leaves SDA released, the strobe low and the registers at their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_a_i | input | 1 | First supply undervoltage flag, restores defaults |
| uvlo_b_i | input | 1 | Second supply undervoltage flag, restores defaults |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High when the pad must pull SDA low |
| regs_o | output | NUM_REGS*8 | All register contents, register i in bits [8i+7:8i] |
| wr_stb_o | output | 1 | One-cycle pulse on each accepted register write |
| wr_addr_o | output | 8 | Pointer of the most recent accepted write |
| wr_data_o | output | 8 | Data of the most recent accepted write |

## Verification
The assertions assume a well-behaved bus master. SDA moves only while SCL is low, except for START and STOP, and every line transition holds for many system clocks so that the synchronized samples see each level. The SDA-drive property also assumes that no STOP arrives while the slave is pulling the line low. The bench master spaces every transition by 32 system clocks and changes data only in the low half of SCL. Before it drives SDA or SCL after the other line has moved, it always returns SCL low, so no unintended START or STOP can appear.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_PTR,
    ST_PACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } bus_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // the last pipeline stage keeps the previous synchronized value
  logic [SYNC_STAGES:0] scl_pipe;
  logic [SYNC_STAGES:0] sda_pipe;
  logic scl_old, sda_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_s   = scl_pipe[SYNC_STAGES-1];
  assign sda_s   = sda_pipe[SYNC_STAGES-1];
  assign scl_old = scl_pipe[SYNC_STAGES];
  assign sda_old = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_old;
  assign scl_fall  = ~scl_s & scl_old;
  assign start_det = scl_s & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_s & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2cs_proto.sv
module i2cs_proto
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1100000,
  parameter int         PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_low_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              wr_req_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  bus_state_t        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              rw_q;
  logic              mack_q;
  logic              byte_done;

  assign byte_done = scl_fall && (bit_cnt_q == LAST_BIT);
  assign wr_req_o  = !stop_det && !start_det && (state_q == ST_WDAT) && byte_done;
  assign wr_data_o = rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b1;
      sda_low_o <= 1'b0;
      ptr_o     <= '0;
    end else if (stop_det) begin
      state_q   <= ST_IDLE;
      sda_low_o <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      sda_low_o <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise && bit_cnt_q != LAST_BIT) begin
            rx_q      <= {rx_q[BYTE_W-2:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
          if (byte_done) begin
            if (state_q == ST_ADDR) begin
              if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
                rw_q      <= rx_q[0];
                sda_low_o <= 1'b1;
                state_q   <= ST_AACK;
              end else begin
                state_q   <= ST_IDLE;
              end
            end else if (state_q == ST_PTR) begin
              ptr_o     <= rx_q;
              sda_low_o <= 1'b1;
              state_q   <= ST_PACK;
            end else begin
              ptr_o     <= ptr_o + 1'b1;
              sda_low_o <= 1'b1;
              state_q   <= ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              tx_q      <= rd_data_i;
              sda_low_o <= ~rd_data_i[BYTE_W-1];
              state_q   <= ST_RDAT;
            end else begin
              sda_low_o <= 1'b0;
              state_q   <= ST_PTR;
            end
          end
        end
        ST_PACK, ST_WACK: begin
          if (scl_fall) begin
            sda_low_o <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise) bit_cnt_q <= bit_cnt_q + 1'b1;
          if (scl_fall) begin
            if (bit_cnt_q == LAST_BIT) begin
              sda_low_o <= 1'b0;
              ptr_o     <= ptr_o + 1'b1;
              state_q   <= ST_RACK;
            end else begin
              sda_low_o <= ~tx_q[BYTE_W-2];
              tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= sda_s;
          if (scl_fall) begin
            if (!mack_q) begin
              tx_q      <= rd_data_i;
              sda_low_o <= ~rd_data_i[BYTE_W-1];
              bit_cnt_q <= '0;
              state_q   <= ST_RDAT;
            end else begin
              state_q   <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R2: own SDA drive moves only while the synchronized clock is low
  p_sda_moves_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_low_o) |-> !scl_s);

  // R2: bit counter never runs past one byte
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    bit_cnt_q <= LAST_BIT);

  // R5: every accepted data byte advances the pointer by one
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    wr_req_o |=> ptr_o == $past(ptr_o) + 1'b1);

  // R7: a STOP returns to idle with SDA released
  p_stop_release_r7: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state_q == ST_IDLE) && !sda_low_o);
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
  import i2cs_pkg::*;
#(
  parameter int                         NUM_REGS = 8,
  parameter int                         PTR_W    = 8,
  parameter logic [NUM_REGS*BYTE_W-1:0] REG_INIT = 64'h1716_1514_1312_1110
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr_i,
  input  logic                       wr_req_i,
  input  logic [PTR_W-1:0]           ptr_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  output logic [BYTE_W-1:0]          rd_data_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat_o,
  output logic                       wr_stb_o,
  output logic [PTR_W-1:0]           wr_addr_o,
  output logic [BYTE_W-1:0]          wr_data_o
);
  logic [BYTE_W-1:0] regs_q [NUM_REGS];
  logic              hit;

  assign hit = ptr_i < PTR_W'(NUM_REGS);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst || clr_i)
        regs_q[g] <= REG_INIT[g*BYTE_W +: BYTE_W];
      else if (wr_req_i && ptr_i == PTR_W'(g))
        regs_q[g] <= wr_data_i;
    end
    assign regs_flat_o[g*BYTE_W +: BYTE_W] = regs_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr_i == PTR_W'(i)) rd_data_o = regs_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= wr_req_i && hit && !clr_i;
      if (wr_req_i && hit && !clr_i) begin
        wr_addr_o <= ptr_i;
        wr_data_o <= wr_data_i;
      end
    end
  end

  // R8: an undervoltage flag restores every default on the next edge
  p_clr_defaults_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> regs_flat_o == REG_INIT);

  // R4: writes beyond the bank leave every register untouched
  p_unimpl_untouched_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_req_i && !hit && !clr_i) |=> $stable(regs_flat_o));

  // R9: the strobe lasts a single cycle
  p_stb_single_r9: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o);
endmodule

// File: rtl/regctl_i2c_slave.sv
module regctl_i2c_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0]                 DEV_ADDR    = 7'b1100000,
  parameter int                         NUM_REGS    = 8,
  parameter int                         PTR_W       = 8,
  parameter int                         SYNC_STAGES = 2,
  parameter logic [NUM_REGS*BYTE_W-1:0] REG_INIT    = 64'h1716_1514_1312_1110
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       uvlo_a_i,
  input  logic                       uvlo_b_i,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_pull_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o,
  output logic                       wr_stb_o,
  output logic [PTR_W-1:0]           wr_addr_o,
  output logic [BYTE_W-1:0]          wr_data_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0]  ptr;
  logic              wr_req;
  logic [BYTE_W-1:0] wr_byte;
  logic [BYTE_W-1:0] rd_byte;

  i2cs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_proto #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_proto (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data_i(rd_byte), .sda_low_o(sda_pull_o), .ptr_o(ptr),
    .wr_req_o(wr_req), .wr_data_o(wr_byte)
  );

  i2cs_regfile #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .REG_INIT(REG_INIT)) u_regs (
    .clk(clk), .rst(rst), .clr_i(uvlo_a_i | uvlo_b_i),
    .wr_req_i(wr_req), .ptr_i(ptr), .wr_data_i(wr_byte),
    .rd_data_o(rd_byte), .regs_flat_o(regs_o),
    .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  // R9: a write strobe coincides with the acknowledge drive
  p_ack_with_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> sda_pull_o);
endmodule

// File: tb/regctl_i2c_slave_test.sv
module regctl_i2c_slave_test;
  localparam int Q = 32;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uvlo_a = 1'b0, uvlo_b = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_bus;
  logic sda_pull;
  logic [NR*8-1:0] regs;
  logic wr_stb;
  logic [7:0] wr_addr, wr_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic stb_at_ack;
  logic [NR*8-1:0] regs_at_ack;
  logic [7:0] model [NR];

  always #10 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  regctl_i2c_slave uut (
    .clk(clk), .rst(rst), .uvlo_a_i(uvlo_a), .uvlo_b_i(uvlo_b),
    .scl_i(m_scl), .sda_i(sda_bus), .sda_pull_o(sda_pull), .regs_o(regs),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  function automatic logic [NR*8-1:0] model_flat();
    logic [NR*8-1:0] f;
    for (int i = 0; i < NR; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic model_defaults();
    for (int i = 0; i < NR; i++) model[i] = 8'h10 + 8'(i);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q(); m_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q(); m_scl = 1'b1; wait_q(); m_sda = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    bit seen = 0;
    stb_at_ack = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_q(); m_scl = 1'b1; wait_q(); m_scl = 1'b0;
      if (i != 0) wait_q();
    end
    for (int k = 0; k < Q; k++) begin
      @(negedge clk);
      if (sda_pull && !seen) begin
        seen = 1; stb_at_ack = wr_stb; regs_at_ack = regs;
      end
    end
    m_sda = 1'b1; wait_q(); m_scl = 1'b1; wait_q();
    acked = ~sda_bus;
    m_scl = 1'b0; wait_q();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      wait_q(); m_scl = 1'b1; wait_q(); b[i] = sda_bus; m_scl = 1'b0;
    end
    wait_q(); m_sda = mack ? 1'b0 : 1'b1; wait_q();
    m_scl = 1'b1; wait_q(); m_scl = 1'b0; wait_q(); m_sda = 1'b1;
  endtask

  task automatic t_reset();
    chk("R10 sda released", sda_pull, 0);
    chk("R10 strobe low", wr_stb, 0);
    chk("R10 defaults", regs, model_flat());
  endtask

  task automatic t_single_write();
    logic a;
    bus_start();
    send_byte(8'hC0, a); chk("R1 address ack", a, 1);
    send_byte(8'h02, a); chk("R4 pointer ack", a, 1);
    send_byte(8'hA5, a); chk("R2 data ack", a, 1);
    chk("R9 strobe at ack", stb_at_ack, 1);
    chk("R9 register at ack", regs_at_ack[2*8 +: 8], 8'hA5);
    bus_stop();
    model[2] = 8'hA5;
    chk("R9 single write", regs, model_flat());
    chk("R9 strobe data", wr_data, 8'hA5);
  endtask

  task automatic t_block_write();
    logic a;
    bus_start();
    send_byte(8'hC0, a); send_byte(8'h05, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    chk("R5 last byte ack", a, 1);
    bus_stop();
    model[5] = 8'h11; model[6] = 8'h22; model[7] = 8'h33;
    chk("R5 block write", regs, model_flat());
    chk("R5 last write pointer", wr_addr, 8'h07);
  endtask

  task automatic t_unimpl();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hC0, a); send_byte(8'hF0, a); chk("R4 high pointer ack", a, 1);
    send_byte(8'h77, a); chk("R4 discarded write ack", a, 1);
    chk("R4 no strobe", stb_at_ack, 0);
    bus_stop();
    chk("R4 registers kept", regs, model_flat());
    bus_start();
    send_byte(8'hC0, a); send_byte(8'h07, a);
    send_byte(8'h5A, a); send_byte(8'h6B, a);
    bus_stop();
    model[7] = 8'h5A;
    chk("R4 write past end dropped", regs, model_flat());
    bus_start();
    send_byte(8'hC0, a); send_byte(8'hF0, a);
    bus_start();
    send_byte(8'hC1, a);
    recv_byte(d, 0);
    chk("R4 unimplemented reads zero", d, 8'h00);
    bus_stop();
  endtask

  task automatic t_read_seq();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hC0, a); send_byte(8'h05, a);
    bus_start();
    send_byte(8'hC1, a); chk("R3 repeated start read address", a, 1);
    recv_byte(d, 1); chk("R6 read byte 0", d, model[5]);
    recv_byte(d, 1); chk("R6 read byte 1", d, model[6]);
    recv_byte(d, 0); chk("R6 read byte 2", d, model[7]);
    recv_byte(d, 0); chk("R6 released after nack", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte(8'hA0, a); chk("R1 foreign address nack", a, 0);
    send_byte(8'hC0, a); chk("R7 ignored after mismatch", a, 0);
    send_byte(8'h00, a); send_byte(8'h55, a);
    chk("R7 no ack while ignoring", a, 0);
    bus_stop();
    chk("R7 registers kept", regs, model_flat());
  endtask

  task automatic t_after_stop();
    logic a;
    m_scl = 1'b0; wait_q();
    send_byte(8'hC0, a); chk("R7 no ack after stop", a, 0);
    send_byte(8'h03, a); send_byte(8'h99, a);
    chk("R7 data ignored after stop", a, 0);
    bus_stop();
    chk("R7 registers kept after stop", regs, model_flat());
  endtask

  task automatic t_uvlo();
    logic a;
    logic [7:0] d;
    @(negedge clk); uvlo_a = 1'b1; @(negedge clk); uvlo_a = 1'b0; @(negedge clk);
    model_defaults();
    chk("R8 first flag restores", regs, model_flat());
    bus_start();
    send_byte(8'hC0, a); send_byte(8'h03, a); send_byte(8'h3C, a);
    bus_stop();
    chk("R8 write before second flag", regs[3*8 +: 8], 8'h3C);
    @(negedge clk); uvlo_b = 1'b1; @(negedge clk); uvlo_b = 1'b0; @(negedge clk);
    chk("R8 second flag restores", regs, model_flat());
    bus_start();
    send_byte(8'hC0, a); send_byte(8'h02, a);
    bus_start();
    send_byte(8'hC1, a); recv_byte(d, 0);
    chk("R6 single read default", d, 8'h12);
    bus_stop();
  endtask

  initial begin
    model_defaults();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_single_write();
    t_block_write();
    t_unimpl();
    t_read_seq();
    t_mismatch();
    t_after_stop();
    t_uvlo();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule